// File: doc/BRIEF.md
# SPI Host Register and Interrupt Block

This block is the processor-side front end of a serial peripheral interface controller on an 8-bit host bus. It decodes three byte registers (transfer data, control and status), drives the control bits toward a separate shift engine, and produces one interrupt line. Write strobes go out toward the engine, and a completion pulse comes back from it.

A single sticky request flag collects three sources. The first is a completion pulse from the shift engine while the engine is enabled. The second is a time-out pulse from the baud-rate counter while the engine is disabled and the counter has been turned into a general timer. The third is a request that software forces through the control register. Software clears the flag by writing a one to it. That same write also drops the forced request. The interrupt line is the flag gated by an enable bit and registered once.

The bus is synchronous. A write takes effect at the clock edge where it is presented. Read data is returned in the cycle after the read strobe.

Top module: `spi_host_regs`

## Requirements
- R1: After a synchronous reset the control register reads 0x00, the request flag is clear, and `irq`, `tx_load`, `tmr_run` and every configuration output are 0.
- R2: The control register at `CTRL_ADDR` reads back the byte last written to it. Bit 7 is the interrupt enable, bit 6 the forced request, bit 5 the timer interrupt enable, bit 4 the clock phase, bit 3 the clock polarity, bit 2 the wired-OR output mode, bit 1 the multi-master enable and bit 0 the engine enable. Bit 6 is the only exception to plain readback: see R3.
- R3: Writing 1 to control bit 6 sets that bit and sets the request flag at the same edge. Writing 0 to control bit 6 leaves it unchanged.
- R4: A write to `STAT_ADDR` with bit 7 set clears the request flag and control bit 6. A write with bit 7 clear changes neither. A status read returns the flag in bit 7 and 0 in bits 6..0.
- R5: `irq` is a register equal to the request flag AND control bit 7, both taken one cycle earlier.
- R6: A pulse on `xfer_done` sets the request flag only while control bit 0 is 1.
- R7: `tmr_run` is 1 exactly when control bit 0 is 0 and bit 5 is 1. A pulse on `tmr_timeout` sets the request flag only while `tmr_run` is 1.
- R8: When a set source and a status clear happen in the same cycle, the flag is left set.
- R9: A write to `DATA_ADDR` raises `tx_load` for exactly the next cycle, with the written byte on `tx_byte`. Back-to-back writes give back-to-back strobes.
- R10: A read of `DATA_ADDR` returns the value of `rx_byte` captured at the most recent `xfer_done`. That capture happens whether or not the engine is enabled.
- R11: `bus_rdata` is valid in the cycle after `bus_rd`. It is 0 in every other cycle and for any address that matches none of the three registers across all `ADDR_W` bits.
- R12: `cfg_phase`, `cfg_polarity`, `cfg_wired_or`, `cfg_multi_master` and `cfg_enable` follow control bits 4, 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after `bus_rd` |
| xfer_done | input | 1 | Transfer-complete pulse from the shift engine |
| rx_byte | input | 8 | Received byte, valid with `xfer_done` |
| tmr_timeout | input | 1 | Time-out pulse from the baud-rate counter |
| tx_load | output | 1 | One-cycle load strobe toward the shift engine |
| tx_byte | output | 8 | Byte to transmit, valid with `tx_load` |
| cfg_phase | output | 1 | Clock phase select |
| cfg_polarity | output | 1 | Idle clock polarity |
| cfg_wired_or | output | 1 | Open-drain output mode |
| cfg_multi_master | output | 1 | Multi-master enable |
| cfg_enable | output | 1 | Engine enable |
| tmr_run | output | 1 | Baud-rate counter runs as a standalone timer |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with `ADDR_W` = 12 and the three registers placed at 0xF60, 0xF61 and 0xF62, instead of the 8-bit defaults. The wider address makes it possible to probe aliases that match the register offsets only in their low byte (0x060, 0x161). Those probes must read 0 and must have no side effect, which confirms the decode compares every address bit. With these values the directed sequences cover the forced request, the timer path in both engine states, and a set colliding with a clear. A long pseudo-random run then mixes all of these against a behavioural model.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_BIT = REG_W - 1;

  typedef struct packed {
    logic irq_en;        // bit 7
    logic force_req;     // bit 6
    logic tmr_irq_en;    // bit 5
    logic phase;         // bit 4
    logic polarity;      // bit 3
    logic wired_or;      // bit 2
    logic multi_master;  // bit 1
    logic engine_en;     // bit 0
  } ctrl_t;
endpackage

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg
  import spi_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             clr_force_i,
  output ctrl_t            ctrl_o,
  output logic             force_set_o
);
  ctrl_t ctrl_q;
  ctrl_t wr_val;

  always_comb begin
    wr_val           = ctrl_t'(wdata_i);
    // a zero written to the forced-request bit keeps it
    wr_val.force_req = wdata_i[6] | ctrl_q.force_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_i)        ctrl_q <= wr_val;
      if (clr_force_i) ctrl_q.force_req <= 1'b0;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign force_set_o = wr_i & wdata_i[6];

  // R3: the forced request stays up until cleared through status
  assert_force_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.force_req && !clr_force_i) |=> ctrl_q.force_req);
  // R4: status clear drops the forced request
  assert_force_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_force_i && !wr_i) |=> !ctrl_q.force_req);
endmodule

// File: rtl/spi_irq_flag.sv
module spi_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (set_i)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      irq_q <= flag_q & en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R8: a set in the same cycle as a clear leaves the flag set
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);
  // R4: a lone clear drops the flag
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
  // R5: a disabled interrupt never reaches the line
  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_q);
endmodule

// File: rtl/spi_data_path.sv
module spi_data_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic [DATA_W-1:0] rx_q_o
);
  logic              load_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      load_q <= wr_i;
      if (wr_i)   tx_q <= wdata_i;
      if (done_i) rx_q <= rx_i;
    end
  end

  assign tx_load_o = load_q;
  assign tx_byte_o = tx_q;
  assign rx_q_o    = rx_q;

  // R9: no strobe without a data write the cycle before
  assert_load_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> !load_q);
  // R10: the received byte holds between completions
  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> $stable(rx_q));
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_regs_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 'h60,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h61,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h62
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              xfer_done,
  input  logic [REG_W-1:0]  rx_byte,
  input  logic              tmr_timeout,
  output logic              tx_load,
  output logic [REG_W-1:0]  tx_byte,
  output logic              cfg_phase,
  output logic              cfg_polarity,
  output logic              cfg_wired_or,
  output logic              cfg_multi_master,
  output logic              cfg_enable,
  output logic              tmr_run,
  output logic              irq
);
  logic             hit_data, hit_ctrl, hit_stat;
  logic             wr_ctrl, wr_data, clr_req;
  logic             force_set, flag, req_set;
  logic [REG_W-1:0] rx_q, rd_mux, rdata_q;
  ctrl_t            ctrl;

  assign hit_data = (bus_addr == DATA_ADDR);
  assign hit_ctrl = (bus_addr == CTRL_ADDR);
  assign hit_stat = (bus_addr == STAT_ADDR);
  assign wr_ctrl  = bus_wr & hit_ctrl;
  assign wr_data  = bus_wr & hit_data;
  assign clr_req  = bus_wr & hit_stat & bus_wdata[FLAG_BIT];

  spi_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (wr_ctrl),
    .wdata_i     (bus_wdata),
    .clr_force_i (clr_req),
    .ctrl_o      (ctrl),
    .force_set_o (force_set)
  );

  assign tmr_run = ~ctrl.engine_en & ctrl.tmr_irq_en;
  assign req_set = (xfer_done & ctrl.engine_en) | (tmr_timeout & tmr_run) | force_set;

  spi_irq_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (req_set),
    .clr_i  (clr_req),
    .en_i   (ctrl.irq_en),
    .flag_o (flag),
    .irq_o  (irq)
  );

  spi_data_path #(.DATA_W(REG_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (wr_data),
    .wdata_i   (bus_wdata),
    .done_i    (xfer_done),
    .rx_i      (rx_byte),
    .tx_load_o (tx_load),
    .tx_byte_o (tx_byte),
    .rx_q_o    (rx_q)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_data)      rd_mux = rx_q;
    else if (hit_ctrl) rd_mux = ctrl;
    else if (hit_stat) rd_mux[FLAG_BIT] = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bus_rd ? rd_mux : '0;
  end

  assign bus_rdata        = rdata_q;
  assign cfg_phase        = ctrl.phase;
  assign cfg_polarity     = ctrl.polarity;
  assign cfg_wired_or     = ctrl.wired_or;
  assign cfg_multi_master = ctrl.multi_master;
  assign cfg_enable       = ctrl.engine_en;

  // R11: no read strobe, no read data
  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
  // R7: timer time-outs are dropped while the engine runs
  assert_tmr_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (tmr_timeout && ctrl.engine_en && !xfer_done && !force_set && !flag) |=> !flag);
  // R6: completions are dropped while the engine is off
  assert_done_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !ctrl.engine_en && !tmr_run && !force_set && !flag) |=> !flag);
endmodule

// File: tb/spi_host_regs_tb.sv
module spi_host_regs_tb;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_DATA = 12'hF60;
  localparam logic [AW-1:0] A_CTRL = 12'hF61;
  localparam logic [AW-1:0] A_STAT = 12'hF62;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, xfer_done = 1'b0, tmr_timeout = 1'b0;
  logic [7:0] bus_wdata = '0, rx_byte = '0;
  logic [7:0] bus_rdata, tx_byte;
  logic tx_load, cfg_phase, cfg_polarity, cfg_wired_or, cfg_multi_master, cfg_enable;
  logic tmr_run, irq;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  logic [7:0] m_ctrl = '0, m_rx = '0, m_rd = '0, m_txb = '0;
  logic m_flag = 1'b0, m_irq = 1'b0, m_txl = 1'b0;
  string m_rtag = "R11";

  always #4 clk = ~clk;

  spi_host_regs #(.ADDR_W(AW), .DATA_ADDR(A_DATA), .CTRL_ADDR(A_CTRL), .STAT_ADDR(A_STAT)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_done(xfer_done), .rx_byte(rx_byte),
    .tmr_timeout(tmr_timeout), .tx_load(tx_load), .tx_byte(tx_byte), .cfg_phase(cfg_phase),
    .cfg_polarity(cfg_polarity), .cfg_wired_or(cfg_wired_or), .cfg_multi_master(cfg_multi_master),
    .cfg_enable(cfg_enable), .tmr_run(tmr_run), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic set, clr, was_flag;
    logic [7:0] old_ctrl;
    old_ctrl = m_ctrl;
    was_flag = m_flag;
    if (rst) begin
      m_ctrl = '0; m_flag = 0; m_irq = 0; m_txl = 0; m_txb = '0; m_rx = '0; m_rd = '0;
      return;
    end
    set = (xfer_done && old_ctrl[0]) || (tmr_timeout && !old_ctrl[0] && old_ctrl[5]) ||
          (bus_wr && bus_addr == A_CTRL && bus_wdata[6]);
    clr = bus_wr && bus_addr == A_STAT && bus_wdata[7];
    if (set) m_flag = 1;
    else if (clr) m_flag = 0;
    if (bus_wr && bus_addr == A_CTRL) m_ctrl = {bus_wdata[7], bus_wdata[6] | old_ctrl[6], bus_wdata[5:0]};
    if (clr) m_ctrl[6] = 0;
    m_irq = was_flag && old_ctrl[7];
    m_txl = bus_wr && bus_addr == A_DATA;
    if (m_txl) m_txb = bus_wdata;
    m_rd = '0;
    m_rtag = "R11";
    if (bus_rd) begin
      if (bus_addr == A_DATA)      begin m_rd = m_rx;            m_rtag = "R10"; end
      else if (bus_addr == A_CTRL) begin m_rd = old_ctrl;        m_rtag = "R2";  end
      else if (bus_addr == A_STAT) begin m_rd = {was_flag, 7'b0}; m_rtag = "R4"; end
    end
    if (xfer_done) m_rx = rx_byte;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R5", {7'b0, irq}, {7'b0, m_irq});
    check("R9", {7'b0, tx_load}, {7'b0, m_txl});
    if (m_txl) check("R9", tx_byte, m_txb);
    check(m_rtag, bus_rdata, m_rd);
    check("R12", {3'b0, cfg_phase, cfg_polarity, cfg_wired_or, cfg_multi_master, cfg_enable},
          {3'b0, m_ctrl[4:0]});
    check("R7", {7'b0, tmr_run}, {7'b0, !m_ctrl[0] && m_ctrl[5]});
    bus_wr = 0; bus_rd = 0; xfer_done = 0; tmr_timeout = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; cyc();
  endtask

  task automatic rd(input logic [AW-1:0] a);
    bus_addr = a; bus_rd = 1; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    @(negedge clk); cyc(); cyc();
    rst = 0;
    // R1: reset state at the ports
    check("R1", {irq, tx_load, tmr_run, cfg_enable, cfg_phase}, 8'h00);
    rd(A_CTRL); cyc();
    check("R1", bus_rdata, 8'h00);
    // R2 / R12: plain readback with configuration bits
    wr(A_CTRL, 8'h9E); rd(A_CTRL); cyc();
    // R3: forced request raises the flag and irq
    wr(A_CTRL, 8'hC1); cyc(); cyc(); rd(A_STAT); cyc();
    wr(A_CTRL, 8'h81); rd(A_CTRL); cyc();   // R3 zero write keeps bit 6
    // R4: zero write to status does nothing, one write clears flag and force bit
    wr(A_STAT, 8'h7F); rd(A_STAT); cyc();
    wr(A_STAT, 8'h80); rd(A_CTRL); rd(A_STAT); cyc(); cyc();
    // R6: completion with engine on, then off
    xfer_done = 1; rx_byte = 8'h5A; cyc(); cyc(); rd(A_STAT); wr(A_STAT, 8'h80);
    wr(A_CTRL, 8'h80); xfer_done = 1; rx_byte = 8'hA5; cyc(); cyc(); rd(A_STAT);
    rd(A_DATA); cyc();                      // R10 captured with engine off
    // R7: timer path
    wr(A_CTRL, 8'hA0); tmr_timeout = 1; cyc(); cyc(); rd(A_STAT); wr(A_STAT, 8'h80);
    wr(A_CTRL, 8'hA1); tmr_timeout = 1; cyc(); cyc(); rd(A_STAT);
    wr(A_CTRL, 8'h80); tmr_timeout = 1; cyc(); cyc(); rd(A_STAT);
    // R8: set and clear together
    wr(A_CTRL, 8'h81); xfer_done = 1; cyc();
    bus_addr = A_STAT; bus_wdata = 8'h80; bus_wr = 1; xfer_done = 1; cyc();
    rd(A_STAT); cyc();
    // R5: interrupt enable gating
    wr(A_CTRL, 8'h01); cyc(); cyc(); wr(A_CTRL, 8'h81); cyc(); cyc();
    // R9: single and back-to-back data writes
    wr(A_DATA, 8'h3C); cyc(); wr(A_DATA, 8'h11); wr(A_DATA, 8'h22); cyc();
    // R11: aliases and unmapped addresses read 0 and change nothing
    rd(12'h060); rd(12'h161); wr(12'h061, 8'hFF); wr(12'h062, 8'h80); rd(12'hF63); rd(A_CTRL); cyc();
    // mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_addr  = {4'hF, 6'b011000, lfsr[1:0]};
      bus_wdata = lfsr[15:8];
      bus_wr    = lfsr[2] & lfsr[3];
      bus_rd    = lfsr[4];
      xfer_done = lfsr[5] & lfsr[6];
      tmr_timeout = lfsr[7] & lfsr[8];
      rx_byte   = lfsr[11:4];
      if (lfsr[9] & lfsr[12] & lfsr[14]) begin rst = 1; cyc(); rst = 0; end
      else cyc();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule